// File: doc/BRIEF.md
# Burst Read Latency Sequencer

This block is the synchronous read-timing core of a 16-bit burst memory. A host starts a read by pulling the address-valid strobe low while the chip is selected. On that clock edge the block captures the start address. It then counts a programmed first-access latency, and after that it streams consecutive words onto the data bus. The latency code is picked to suit the clock rate. Code 2 suits about 20 MHz, code 3 about 33 MHz, and code 4 rates up to about 50 MHz. The number of clocks to the first word is always the code plus one.

Each word can be held on the bus for one clock or for two. A wait output, which is active low and meant to be wired-OR into the host's ready line, tells the host when the bus carries no fresh word. Words come from a behavioural array over a request/valid handshake. The array may refuse a request, and the block then inserts wait states until the word arrives. The burst address advances linearly or wraps inside an aligned block of 4, 8 or 16 words.

The controller is a four-state machine:
- `S_IDLE`: no burst is running.
- `S_LAT`: the latency count is running, or a word fetch is being retried.
- `S_WORD1`: the first clock of a word on the bus.
- `S_WORD2`: the second clock of a word, used only in two-clock hold.

Transitions:
- Any state goes to `S_LAT` on a strobe sampled low with the chip selected. This starts a new burst and aborts any burst in progress.
- Any state goes to `S_IDLE` when the chip is deselected.
- `S_LAT` goes to `S_WORD1` when the count reaches its last clock and the array accepts the fetch. If the array refuses, the block stays in `S_LAT`.
- `S_WORD1` goes to `S_WORD2` in two-clock hold.
- In one-clock hold, `S_WORD1` loads the next word and stays in `S_WORD1`.
- `S_WORD2` loads the next word and returns to `S_WORD1`.
- From either word state, a refused fetch sends the machine back to `S_LAT` with a count of one.

Top module: `burst_rd_seq`

## Requirements
- R1: After reset, and with no burst started, `dq_oe` is 0, `wait_n` is 1, `mem_req` is 0 and `dq_out` is 0.
- R2: Call the clock edge where `adv_n`=0 and `ce_n`=0 are sampled edge E0. The first word, taken from the captured address, appears on `dq_out` with `dq_oe`=1 right after edge E0+N, where N = `cfg_lat_code`+1 for codes 2, 3 and 4. Before that edge, `dq_oe` is 0.
- R3: A latency code outside 2..4 (0, 1, 5, 6, 7) behaves exactly as code 4, so N is 5.
- R4: With `cfg_hold2`=0 a new word appears on every clock. With `cfg_hold2`=1 each word stays unchanged for exactly two clocks.
- R5: `wait_n` is 0 from edge E0 until the first word is driven. In two-clock hold it is also 0 on the second clock of each word. Otherwise it is 1 while a word is driven.
- R6: Each successive word comes from the next burst address. `cfg_wrap` selects the addressing: 0 is linear, modulo 2^21; 1, 2 and 3 wrap within an aligned block of 4, 8 and 16 words, leaving the upper address bits unchanged.
- R7: A new strobe during a burst aborts it. The latency count restarts from the new address, and `dq_oe` drops after that edge.
- R8: With `oe_n`=1, `dq_oe` is 0 and `wait_n` is 1, and the burst keeps advancing. With `ce_n`=1, the same two outputs apply, the burst ends, and no words are fetched until the next strobe.
- R9: In the clock before each word is loaded, `mem_req` is 1 and `mem_addr` holds that word's address. If `mem_vld` is 0 in that clock, no word is loaded, `dq_oe` is 0 and `wait_n` is 0 for one clock, and the fetch is retried.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| adv_n | input | 1 | Address-valid strobe, active low |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 21 | Burst start address |
| cfg_lat_code | input | 3 | First-access latency code |
| cfg_hold2 | input | 1 | 1: hold each word two clocks |
| cfg_wrap | input | 2 | Burst addressing mode |
| mem_req | output | 1 | Word fetch request to array |
| mem_addr | output | 21 | Address of requested word |
| mem_vld | input | 1 | Array accepts the fetch this clock |
| mem_data | input | 16 | Array data for the fetch |
| dq_out | output | 16 | Data bus value |
| dq_oe | output | 1 | Data bus drive enable |
| wait_n | output | 1 | Wait indication, active low |

## Verification
The bench uses the default parameters: a 21-bit address, 16-bit words and codes limited to 2..4. With these, all three legal codes and two illegal ones (0 and 7) can be compared directly, as can all four addressing modes. A linear burst is started at the top of the 21-bit space so that it crosses zero, and wrapping bursts are started near the ends of their blocks. The array model can refuse a fetch, so the retry path is exercised both at the first word and in mid-burst.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_LAT   = 2'd1,
        S_WORD1 = 2'd2,
        S_WORD2 = 2'd3
    } seq_state_t;

endpackage

// File: rtl/bseq_lat_ctr.sv
module bseq_lat_ctr #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt,
    output logic             last
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign last = (cnt == CNT_W'(1));

    // R2
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load) |-> (cnt != '0));

endmodule

// File: rtl/bseq_addr_gen.sv
module bseq_addr_gen #(
    parameter int ADDR_W = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              step,
    input  logic [1:0]        wrap_sel,
    output logic [ADDR_W-1:0] addr
);

    logic [ADDR_W-1:0] inc_mask;
    logic [ADDR_W-1:0] addr_inc;
    logic [ADDR_W-1:0] addr_next;

    // bit i follows the increment when linear, or when it sits inside the wrap block
    for (genvar i = 0; i < ADDR_W; i++) begin : g_mask
        assign inc_mask[i] = (wrap_sel == 2'd0) || (i <= int'(wrap_sel));
    end

    assign addr_inc  = addr + ADDR_W'(1);
    assign addr_next = (addr & ~inc_mask) | (addr_inc & inc_mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load) begin
            addr <= load_addr;
        end else if (step) begin
            addr <= addr_next;
        end
    end

    // R6
    wrap_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && wrap_sel == 2'd1) |=> (addr[ADDR_W-1:2] == $past(addr[ADDR_W-1:2])));

endmodule

// File: rtl/bseq_word_reg.sv
module bseq_word_reg #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/burst_rd_seq.sv
module burst_rd_seq #(
    parameter int ADDR_W   = 21,
    parameter int DATA_W   = 16,
    parameter int CODE_W   = 3,
    parameter int CODE_MIN = 2,
    parameter int CODE_MAX = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CODE_W-1:0] cfg_lat_code,
    input  logic              cfg_hold2,
    input  logic [1:0]        cfg_wrap,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_vld,
    input  logic [DATA_W-1:0] mem_data,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic              wait_n
);

    import bseq_pkg::*;

    localparam int LAT_MAX = CODE_MAX + 1;
    localparam int CNT_W   = $clog2(LAT_MAX + 1);

    seq_state_t        state_q;
    seq_state_t        state_d;
    logic [CODE_W-1:0] code_eff;
    logic [CNT_W-1:0]  first_lat;
    logic [CNT_W-1:0]  cnt_val;
    logic [CNT_W-1:0]  cnt;
    logic              cnt_last;
    logic              cnt_load;
    logic              cnt_dec;
    logic              addr_load;
    logic              addr_step;
    logic              word_load;
    logic              adv_evt;
    logic              out_act;
    logic              word_active;

    // out-of-range codes fall back to the longest latency
    assign code_eff  = (cfg_lat_code >= CODE_W'(CODE_MIN) && cfg_lat_code <= CODE_W'(CODE_MAX))
                       ? cfg_lat_code : CODE_W'(CODE_MAX);
    assign first_lat = CNT_W'(code_eff) + CNT_W'(1);
    assign adv_evt   = !adv_n && !ce_n;

    bseq_lat_ctr #(.CNT_W(CNT_W)) i_lat_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .dec      (cnt_dec),
        .cnt      (cnt),
        .last     (cnt_last)
    );

    bseq_addr_gen #(.ADDR_W(ADDR_W)) i_addr_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (addr_load),
        .load_addr (addr),
        .step      (addr_step),
        .wrap_sel  (cfg_wrap),
        .addr      (mem_addr)
    );

    bseq_word_reg #(.DATA_W(DATA_W)) i_word_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (word_load),
        .d     (mem_data),
        .q     (dq_out)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and datapath controls
    always_comb begin
        state_d   = state_q;
        cnt_load  = 1'b0;
        cnt_val   = first_lat;
        cnt_dec   = 1'b0;
        addr_load = 1'b0;
        addr_step = 1'b0;
        word_load = 1'b0;
        mem_req   = 1'b0;
        if (ce_n) begin
            state_d = S_IDLE;
        end else if (adv_evt) begin
            state_d   = S_LAT;
            cnt_load  = 1'b1;
            addr_load = 1'b1;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    state_d = S_IDLE;
                end
                S_LAT: begin
                    if (cnt_last) begin
                        mem_req = 1'b1;
                        if (mem_vld) begin
                            state_d   = S_WORD1;
                            word_load = 1'b1;
                            addr_step = 1'b1;
                        end
                    end else begin
                        cnt_dec = 1'b1;
                    end
                end
                S_WORD1, S_WORD2: begin
                    if (state_q == S_WORD1 && cfg_hold2) begin
                        state_d = S_WORD2;
                    end else begin
                        mem_req = 1'b1;
                        if (mem_vld) begin
                            state_d   = S_WORD1;
                            word_load = 1'b1;
                            addr_step = 1'b1;
                        end else begin
                            state_d  = S_LAT;
                            cnt_load = 1'b1;
                            cnt_val  = CNT_W'(1);
                        end
                    end
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        out_act     = !ce_n && !oe_n;
        word_active = (state_q == S_WORD1) || (state_q == S_WORD2);
        dq_oe       = out_act && word_active;
        wait_n      = !(out_act && (state_q == S_LAT || state_q == S_WORD2));
    end

    // R2
    lat_cnt_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_LAT) |-> (cnt != '0));

    // R2
    first_word_from_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(word_active) |-> ($past(state_q) == S_LAT));

    // R4
    hold_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WORD2) |-> ($past(state_q) == S_WORD1 && $stable(dq_out)));

    // R8
    deselect_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> (state_q == S_IDLE));

endmodule

// File: tb/test_burst_rd_seq.sv
module test_burst_rd_seq;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 21;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          adv_n = 1'b1;
    logic          ce_n = 1'b0;
    logic          oe_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [2:0]    cfg_lat_code = 3'd2;
    logic          cfg_hold2 = 1'b0;
    logic [1:0]    cfg_wrap = 2'd0;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic          mem_vld;
    logic [DW-1:0] mem_data;
    logic [DW-1:0] dq_out;
    logic          dq_oe;
    logic          wait_n;
    logic          mem_block = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [DW-1:0] fdata(input logic [AW-1:0] a);
        return a[15:0] ^ 16'h3C5A ^ {11'd0, a[20:16]};
    endfunction

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] a, input logic [1:0] w);
        logic [AW-1:0] m;
        case (w)
            2'd1:    m = 21'h3;
            2'd2:    m = 21'h7;
            2'd3:    m = 21'hF;
            default: m = '1;
        endcase
        return (a & ~m) | ((a + 21'd1) & m);
    endfunction

    assign mem_vld  = mem_req && !mem_block;
    assign mem_data = mem_req ? fdata(mem_addr) : '0;

    burst_rd_seq i_burst_rd_seq (
        .clk(clk), .rst_n(rst_n), .adv_n(adv_n), .ce_n(ce_n), .oe_n(oe_n),
        .addr(addr), .cfg_lat_code(cfg_lat_code), .cfg_hold2(cfg_hold2),
        .cfg_wrap(cfg_wrap), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_vld(mem_vld), .mem_data(mem_data), .dq_out(dq_out),
        .dq_oe(dq_oe), .wait_n(wait_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic deselect();
        ce_n = 1'b1;
        tick();
        ce_n = 1'b0;
        #1;
        check("R1 idle dq_oe", 32'(dq_oe), 0);
        check("R1 idle wait_n", 32'(wait_n), 1);
    endtask

    // starts a burst (aborting any running one) and checks latency, hold, wait, addresses
    task automatic run_burst(input logic [2:0] code, input logic hold2, input logic [1:0] wrap,
                             input logic [AW-1:0] start, input int words, input string ctx);
        int n;
        logic [AW-1:0] a;
        n = (code >= 3'd2 && code <= 3'd4) ? int'(code) + 1 : 5;
        a = start;
        cfg_lat_code = code;
        cfg_hold2 = hold2;
        cfg_wrap = wrap;
        adv_n = 1'b0;
        addr = start;
        tick();
        adv_n = 1'b1;
        check({"R5 wait after strobe ", ctx}, 32'(wait_n), 0);
        check({"R2 no drive after strobe ", ctx}, 32'(dq_oe), 0);
        for (int k = 1; k <= n; k++) begin
            tick();
            if (k < n) begin
                check({"R2 latency dq_oe ", ctx}, 32'(dq_oe), 0);
                check({"R5 latency wait ", ctx}, 32'(wait_n), 0);
            end else begin
                check({"R2 R3 first word dq_oe ", ctx}, 32'(dq_oe), 1);
            end
        end
        for (int w = 0; w < words; w++) begin
            check({"R6 word data ", ctx}, 32'(dq_out), 32'(fdata(a)));
            check({"R5 wait on word ", ctx}, 32'(wait_n), 1);
            if (hold2) begin
                tick();
                check({"R4 held data ", ctx}, 32'(dq_out), 32'(fdata(a)));
                check({"R5 wait second clock ", ctx}, 32'(wait_n), 0);
                check({"R4 still driven ", ctx}, 32'(dq_oe), 1);
            end
            tick();
            a = nxt(a, wrap);
        end
    endtask

    task automatic t_reset();
        check("R1 dq_oe", 32'(dq_oe), 0);
        check("R1 wait_n", 32'(wait_n), 1);
        check("R1 mem_req", 32'(mem_req), 0);
        check("R1 dq_out", 32'(dq_out), 0);
    endtask

    task automatic t_codes_holds();
        for (int c = 2; c <= 4; c++) begin
            for (int h = 0; h < 2; h++) begin
                run_burst(3'(c), 1'(h), 2'd0, 21'h01230, 5, "R2 R4 sweep");
                deselect();
            end
        end
    endtask

    task automatic t_bad_codes();
        run_burst(3'd0, 1'b0, 2'd0, 21'h00400, 3, "R3 code0");
        deselect();
        run_burst(3'd7, 1'b1, 2'd0, 21'h00500, 3, "R3 code7");
        deselect();
    endtask

    task automatic t_wraps();
        run_burst(3'd2, 1'b0, 2'd1, 21'h00106, 6, "R6 wrap4");
        deselect();
        run_burst(3'd3, 1'b1, 2'd2, 21'h1FFFE, 6, "R6 wrap8");
        deselect();
        run_burst(3'd2, 1'b0, 2'd3, 21'h0000D, 8, "R6 wrap16");
        deselect();
        run_burst(3'd4, 1'b0, 2'd0, 21'h1FFFFE, 4, "R6 linear top");
        deselect();
    endtask

    task automatic t_abort();
        run_burst(3'd3, 1'b0, 2'd0, 21'h00A00, 2, "R7 first");
        run_burst(3'd2, 1'b1, 2'd2, 21'h00B05, 4, "R7 restarted");
        deselect();
    endtask

    task automatic t_oe_ce();
        run_burst(3'd2, 1'b0, 2'd0, 21'h00C00, 1, "R8 base");
        oe_n = 1'b1;
        #1;
        check("R8 oe off dq_oe", 32'(dq_oe), 0);
        check("R8 oe off wait_n", 32'(wait_n), 1);
        tick();
        tick();
        oe_n = 1'b0;
        #1;
        check("R8 burst advanced", 32'(dq_out), 32'(fdata(21'h00C03)));
        check("R8 oe back dq_oe", 32'(dq_oe), 1);
        ce_n = 1'b1;
        #1;
        check("R8 ce off dq_oe", 32'(dq_oe), 0);
        check("R8 ce off wait_n", 32'(wait_n), 1);
        tick();
        ce_n = 1'b0;
        for (int i = 0; i < 6; i++) tick();
        check("R8 burst ended dq_oe", 32'(dq_oe), 0);
        check("R8 burst ended mem_req", 32'(mem_req), 0);
    endtask

    task automatic t_stall();
        logic [AW-1:0] a;
        a = 21'h00D10;
        cfg_lat_code = 3'd2;
        cfg_hold2 = 1'b0;
        cfg_wrap = 2'd0;
        adv_n = 1'b0;
        addr = a;
        tick();
        adv_n = 1'b1;
        tick();
        tick();
        check("R9 request before first word", 32'(mem_req), 1);
        check("R9 request address", 32'(mem_addr), 32'(a));
        mem_block = 1'b1;
        tick();
        check("R9 refused dq_oe", 32'(dq_oe), 0);
        check("R9 refused wait_n", 32'(wait_n), 0);
        mem_block = 1'b0;
        tick();
        check("R9 retried first word", 32'(dq_out), 32'(fdata(a)));
        check("R9 retried dq_oe", 32'(dq_oe), 1);
        tick();
        check("R9 second word", 32'(dq_out), 32'(fdata(a + 21'd1)));
        mem_block = 1'b1;
        tick();
        check("R9 mid refused dq_oe", 32'(dq_oe), 0);
        check("R9 mid refused wait_n", 32'(wait_n), 0);
        check("R9 mid retry address", 32'(mem_addr), 32'(a + 21'd2));
        mem_block = 1'b0;
        tick();
        check("R9 mid retried word", 32'(dq_out), 32'(fdata(a + 21'd2)));
        check("R9 mid retried wait_n", 32'(wait_n), 1);
        deselect();
    endtask

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        tick();
        tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_codes_holds();
        t_bad_codes();
        t_wraps();
        t_abort();
        t_oe_ce();
        t_stall();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule